// File: doc/BRIEF.md
# Byte FIFO Pair with Level-Threshold Service Requests

This block sits between a 32-bit register-style data port and a serial shift engine. It holds two byte FIFOs. The transmit FIFO is loaded from the bus and drained one byte at a time by the engine. The receive FIFO is filled one byte at a time by the engine and drained from the bus. A single bus access moves one, two or four bytes, with the lowest byte lane going first.

Each direction has a 2-bit level code. The code sets how much room (transmit) or how much data (receive) must be present before a service request is raised. The same request is also offered on a DMA request line when DMA is enabled. Counts and both ring pointers of each FIFO are visible as status outputs.

Faulty traffic raises one-cycle event pulses for an interrupt flag block elsewhere. There is an overrun event for each FIFO and an illegal-access event for each FIFO. Each FIFO can be flushed without disturbing the other.

Top module: `spf_fifo_pair`

## Requirements
- R1: After reset both counts and all four pointers are 0, the transmit request is 1, the receive request is 0 and no event is pending.
- R2: A transmit write of size code 0, 1, 2 or 3 pushes 1, 2, 4 or 4 bytes, taken from bit lanes [7:0] upward. `eng_tx_byte` always presents the oldest transmit byte.
- R3: A legal receive read of N bytes returns the oldest byte in `acc_rdata[7:0]`, the next in [15:8] and so on, and 0 in the unused lanes. When no receive pop takes place, `acc_rdata` is 0.
- R4: `rx_req` is 1 exactly when the filled receive slots are at least the need of `rx_level_sel`. The need is 1, 2, 4 or DEPTH for codes 0, 1, 2 and 3.
- R5: `tx_req` is 1 exactly when the empty transmit slots are at least the need of `tx_level_sel`, using the same code-to-need mapping as R4.
- R6: Each DMA request equals its service request while `dma_en` is 1 and is 0 while `dma_en` is 0.
- R7: Each count equals the bytes held. Each write pointer advances by the bytes pushed and each read pointer by the bytes popped, both modulo DEPTH.
- R8: A flush empties only its own FIFO and zeroes that FIFO's pointers and count. An access to that FIFO in the same cycle is dropped and raises no event.
- R9: A transmit write larger than the free space pushes nothing and pulses `tx_ovr_evt` in the next cycle.
- R10: An engine byte that arrives while the receive FIFO is full is discarded and pulses `rx_ovr_evt` in the next cycle.
- R11: Three accesses pulse the illegal-access event of the addressed FIFO in the next cycle and change nothing: a receive read of more bytes than are held, any write to the receive side, and any read of the transmit side.
- R12: Legality is judged on the state at the start of the cycle. A push and a pop of equal size in the same cycle leave the count unchanged.
- R13: An engine take from an empty transmit FIFO is ignored and `eng_tx_ready` is 0 while the transmit FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Bus access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_rx_side | input | 1 | 1 = receive FIFO addressed, 0 = transmit FIFO addressed |
| acc_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| acc_wdata | input | 32 | Write data, lowest lane first |
| acc_rdata | output | 32 | Read data of a receive pop |
| eng_rx_valid | input | 1 | Engine delivers one received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_tx_take | input | 1 | Engine consumes the head transmit byte |
| eng_tx_byte | output | 8 | Head transmit byte |
| eng_tx_ready | output | 1 | Transmit FIFO holds at least one byte |
| tx_flush | input | 1 | Empty the transmit FIFO |
| rx_flush | input | 1 | Empty the receive FIFO |
| tx_level_sel | input | 2 | Transmit request level code |
| rx_level_sel | input | 2 | Receive request level code |
| dma_en | input | 1 | Route requests to the DMA request outputs |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_ovr_evt | output | 1 | Transmit overrun pulse |
| rx_ovr_evt | output | 1 | Receive overrun pulse |
| tx_ill_evt | output | 1 | Transmit illegal-access pulse |
| rx_ill_evt | output | 1 | Receive illegal-access pulse |
| tx_rd_ptr | output | 4 | Transmit read pointer |
| tx_wr_ptr | output | 4 | Transmit write pointer |
| tx_count | output | 4 | Transmit bytes held |
| rx_rd_ptr | output | 4 | Receive read pointer |
| rx_wr_ptr | output | 4 | Receive write pointer |
| rx_count | output | 4 | Receive bytes held |

## Verification
The transmit side is driven with word, halfword and byte writes in a mix that leaves the free space at 3. This separates the all-or-nothing overrun rule from a partial push. The engine output order then exposes any lane-order mistake.

The receive side is filled to full and past it, then drained with halfword and word reads. This walks the pointers around the ring and shows that a short read is refused rather than trimmed.

Every level code is stepped through at empty, partial and full occupancy, with DMA both on and off. This distinguishes "at least" from "more than" and the filled-slot count from the empty-slot count.

Same-cycle push and pop, and flush combined with an access, check the start-of-cycle legality rule and the isolation of the two FIFOs.

// File: rtl/spf_pkg.sv
`timescale 1ns/1ps
package spf_pkg;

   // bytes moved by one bus access, clipped to the bus width
   function automatic int spf_bytes(input logic [1:0] sz, input int max_bytes);
      int n;
      n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      return (n > max_bytes) ? max_bytes : n;
   endfunction

   // slots needed before a request is raised, per level code
   function automatic int spf_need(input logic [1:0] code, input int depth);
      case (code)
         2'd0:    return 1;
         2'd1:    return 2;
         2'd2:    return 4;
         default: return depth;
      endcase
   endfunction

endpackage

// File: rtl/spf_level_req.sv
`timescale 1ns/1ps
module spf_level_req #(
   parameter int DEPTH = 8,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic [CW-1:0] level,
   input  logic [1:0]    sel,
   output logic          req
);
   logic [CW-1:0] need;

   assign need = CW'(spf_pkg::spf_need(sel, DEPTH));
   assign req  = (level >= need);
endmodule

// File: rtl/spf_ring.sv
`timescale 1ns/1ps
module spf_ring #(
   parameter int DEPTH    = 8,
   parameter int BW       = 8,
   parameter int PUSH_MAX = 1,
   parameter int POP_MAX  = 1,
   localparam int PW      = $clog2(DEPTH),
   localparam int CW      = $clog2(DEPTH + 1),
   localparam int PNW     = $clog2(PUSH_MAX + 1),
   localparam int QNW     = $clog2(POP_MAX + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   flush,
   input  logic                   push_en,
   input  logic [PNW-1:0]         push_n,
   input  logic [PUSH_MAX*BW-1:0] push_data,
   input  logic                   pop_en,
   input  logic [QNW-1:0]         pop_n,
   output logic [POP_MAX*BW-1:0]  peek_data,
   output logic [PW-1:0]          rptr,
   output logic [PW-1:0]          wptr,
   output logic [CW-1:0]          cnt
);
   logic [BW-1:0] mem [DEPTH];
   logic [CW-1:0] add_n, sub_n;

   assign add_n = push_en ? CW'(push_n) : '0;
   assign sub_n = pop_en  ? CW'(pop_n)  : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr <= '0;
         wptr <= '0;
         cnt  <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (flush) begin
         rptr <= '0;
         wptr <= '0;
         cnt  <= '0;
      end else begin
         if (push_en) begin
            for (int i = 0; i < PUSH_MAX; i++)
               if (i < int'(push_n)) mem[wptr + PW'(i)] <= push_data[i*BW +: BW];
            wptr <= wptr + PW'(push_n);
         end
         if (pop_en) rptr <= rptr + PW'(pop_n);
         cnt <= cnt + add_n - sub_n;
      end
   end

   for (genvar j = 0; j < POP_MAX; j++) begin : g_peek
      assign peek_data[j*BW +: BW] = mem[rptr + PW'(j)];
   end

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      push_en |-> (int'(cnt) + int'(push_n) <= DEPTH));
   assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pop_en |-> (int'(cnt) >= int'(pop_n)));
   assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt == '0 && rptr == wptr));
   assert_count_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (push_en && pop_en && !flush && int'(push_n) == int'(pop_n)) |=> $stable(cnt));
endmodule

// File: rtl/spf_fifo_pair.sv
`timescale 1ns/1ps
module spf_fifo_pair #(
   parameter int DEPTH     = 8,
   parameter int BW        = 8,
   parameter int BUS_BYTES = 4,
   parameter int STAT_W    = 4,
   localparam int BUS_W    = BUS_BYTES * BW,
   localparam int PW       = $clog2(DEPTH),
   localparam int CW       = $clog2(DEPTH + 1),
   localparam int NW       = $clog2(BUS_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic              acc_rx_side,
   input  logic [1:0]        acc_size,
   input  logic [BUS_W-1:0]  acc_wdata,
   output logic [BUS_W-1:0]  acc_rdata,
   input  logic              eng_rx_valid,
   input  logic [BW-1:0]     eng_rx_byte,
   input  logic              eng_tx_take,
   output logic [BW-1:0]     eng_tx_byte,
   output logic              eng_tx_ready,
   input  logic              tx_flush,
   input  logic              rx_flush,
   input  logic [1:0]        tx_level_sel,
   input  logic [1:0]        rx_level_sel,
   input  logic              dma_en,
   output logic              tx_req,
   output logic              rx_req,
   output logic              tx_dma_req,
   output logic              rx_dma_req,
   output logic              tx_ovr_evt,
   output logic              rx_ovr_evt,
   output logic              tx_ill_evt,
   output logic              rx_ill_evt,
   output logic [STAT_W-1:0] tx_rd_ptr,
   output logic [STAT_W-1:0] tx_wr_ptr,
   output logic [STAT_W-1:0] tx_count,
   output logic [STAT_W-1:0] rx_rd_ptr,
   output logic [STAT_W-1:0] rx_wr_ptr,
   output logic [STAT_W-1:0] rx_count
);
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 4) begin : g_bad_depth
      $error("DEPTH must be a power of two and at least 4");
   end
   if (!(BUS_BYTES == 1 || BUS_BYTES == 2 || BUS_BYTES == 4) || DEPTH < BUS_BYTES) begin : g_bad_bus
      $error("BUS_BYTES must be 1, 2 or 4 and no larger than DEPTH");
   end
   if (DEPTH >= (1 << STAT_W)) begin : g_bad_stat
      $error("STAT_W too narrow for the count");
   end

   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   logic [NW-1:0]    acc_n;
   logic [PW-1:0]    tx_rptr, tx_wptr, rx_rptr, rx_wptr;
   logic [CW-1:0]    tx_cnt, rx_cnt, tx_free;
   logic [BW-1:0]    tx_peek;
   logic [BUS_W-1:0] rx_peek;
   logic wr_tx, rd_tx, wr_rx, rd_rx, tx_fit, rx_have;
   logic tx_push_en, tx_pop_en, rx_push_en, rx_pop_en;
   logic tx_ovr_d, rx_ovr_d, tx_ill_d, rx_ill_d;

   assign acc_n   = NW'(spf_pkg::spf_bytes(acc_size, BUS_BYTES));
   assign tx_free = FULL - tx_cnt;
   assign wr_tx   = acc_valid &  acc_write & ~acc_rx_side;
   assign rd_tx   = acc_valid & ~acc_write & ~acc_rx_side;
   assign wr_rx   = acc_valid &  acc_write &  acc_rx_side;
   assign rd_rx   = acc_valid & ~acc_write &  acc_rx_side;
   assign tx_fit  = CW'(acc_n) <= tx_free;
   assign rx_have = rx_cnt >= CW'(acc_n);

   // transmit side: bus pushes, engine pops one byte
   assign tx_push_en = wr_tx & tx_fit & ~tx_flush;
   assign tx_ovr_d   = wr_tx & ~tx_fit & ~tx_flush;
   assign tx_ill_d   = rd_tx & ~tx_flush;
   assign tx_pop_en  = eng_tx_take & (tx_cnt != '0) & ~tx_flush;

   // receive side: engine pushes one byte, bus pops
   assign rx_push_en = eng_rx_valid & (rx_cnt != FULL) & ~rx_flush;
   assign rx_ovr_d   = eng_rx_valid & (rx_cnt == FULL) & ~rx_flush;
   assign rx_pop_en  = rd_rx & rx_have & ~rx_flush;
   assign rx_ill_d   = ((rd_rx & ~rx_have) | wr_rx) & ~rx_flush;

   spf_ring #(.DEPTH(DEPTH), .BW(BW), .PUSH_MAX(BUS_BYTES), .POP_MAX(1)) u_tx_ring (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush),
      .push_en(tx_push_en), .push_n(acc_n), .push_data(acc_wdata),
      .pop_en(tx_pop_en), .pop_n(1'b1), .peek_data(tx_peek),
      .rptr(tx_rptr), .wptr(tx_wptr), .cnt(tx_cnt));

   spf_ring #(.DEPTH(DEPTH), .BW(BW), .PUSH_MAX(1), .POP_MAX(BUS_BYTES)) u_rx_ring (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush),
      .push_en(rx_push_en), .push_n(1'b1), .push_data(eng_rx_byte),
      .pop_en(rx_pop_en), .pop_n(acc_n), .peek_data(rx_peek),
      .rptr(rx_rptr), .wptr(rx_wptr), .cnt(rx_cnt));

   spf_level_req #(.DEPTH(DEPTH), .CW(CW)) u_tx_level (
      .level(tx_free), .sel(tx_level_sel), .req(tx_req));
   spf_level_req #(.DEPTH(DEPTH), .CW(CW)) u_rx_level (
      .level(rx_cnt), .sel(rx_level_sel), .req(rx_req));

   for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
      assign acc_rdata[k*BW +: BW] = (rx_pop_en && (NW'(k) < acc_n)) ? rx_peek[k*BW +: BW] : '0;
   end

   assign eng_tx_byte  = tx_peek;
   assign eng_tx_ready = (tx_cnt != '0);
   assign tx_dma_req   = tx_req & dma_en;
   assign rx_dma_req   = rx_req & dma_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_ovr_evt <= 1'b0;
         rx_ovr_evt <= 1'b0;
         tx_ill_evt <= 1'b0;
         rx_ill_evt <= 1'b0;
      end else begin
         tx_ovr_evt <= tx_ovr_d;
         rx_ovr_evt <= rx_ovr_d;
         tx_ill_evt <= tx_ill_d;
         rx_ill_evt <= rx_ill_d;
      end
   end

   assign tx_rd_ptr = STAT_W'(tx_rptr);
   assign tx_wr_ptr = STAT_W'(tx_wptr);
   assign tx_count  = STAT_W'(tx_cnt);
   assign rx_rd_ptr = STAT_W'(rx_rptr);
   assign rx_wr_ptr = STAT_W'(rx_wptr);
   assign rx_count  = STAT_W'(rx_cnt);

   assert_ovr_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ovr_evt |-> $past(acc_valid && acc_write && !acc_rx_side));
   assert_rx_ovr_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ovr_evt |-> ($past(rx_cnt) == FULL));
   assert_rx_full_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt == FULL) |-> rx_req);
   assert_tx_empty_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cnt == '0) |-> tx_req);
endmodule

// File: tb/spf_fifo_pair_test.sv
`timescale 1ns/1ps
module spf_fifo_pair_test;
   localparam int DEPTH = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n;
   logic        acc_valid, acc_write, acc_rx_side;
   logic [1:0]  acc_size;
   logic [31:0] acc_wdata, acc_rdata;
   logic        eng_rx_valid, eng_tx_take, eng_tx_ready;
   logic [7:0]  eng_rx_byte, eng_tx_byte;
   logic        tx_flush, rx_flush, dma_en;
   logic [1:0]  tx_level_sel, rx_level_sel;
   logic        tx_req, rx_req, tx_dma_req, rx_dma_req;
   logic        tx_ovr_evt, rx_ovr_evt, tx_ill_evt, rx_ill_evt;
   logic [3:0]  tx_rd_ptr, tx_wr_ptr, tx_count, rx_rd_ptr, rx_wr_ptr, rx_count;

   spf_fifo_pair uut (.*);

   int total = 0, bad = 0;
   byte unsigned txq[$], rxq[$];
   int tx_r = 0, tx_w = 0, rx_r = 0, rx_w = 0;

   task automatic chk(input string tag, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic int need_of(input logic [1:0] c);
      return (c == 0) ? 1 : (c == 1) ? 2 : (c == 2) ? 4 : DEPTH;
   endfunction

   task automatic idle();
      acc_valid = 0; acc_write = 0; acc_rx_side = 0; acc_size = 0; acc_wdata = 0;
      eng_rx_valid = 0; eng_rx_byte = 0; eng_tx_take = 0; tx_flush = 0; rx_flush = 0;
   endtask

   // one clock: combinational checks before the edge, model update and registered checks after
   task automatic tick();
      int n, txs, rxs;
      logic wtx, rtx, wrx, rrx;
      logic e_txo, e_rxo, e_txi, e_rxi;
      longint exp_rd;
      #5;
      n   = (acc_size == 0) ? 1 : (acc_size == 1) ? 2 : 4;
      txs = txq.size(); rxs = rxq.size();
      wtx = acc_valid &  acc_write & !acc_rx_side;
      rtx = acc_valid & !acc_write & !acc_rx_side;
      wrx = acc_valid &  acc_write &  acc_rx_side;
      rrx = acc_valid & !acc_write &  acc_rx_side;
      exp_rd = 0;
      if (rrx && !rx_flush && rxs >= n)
         for (int k = 0; k < n; k++) exp_rd |= longint'(rxq[k]) << (8 * k);
      chk("R3 rdata", acc_rdata, exp_rd);
      chk("R13 tx ready", eng_tx_ready, txs != 0);
      if (txs != 0) chk("R2 tx head byte", eng_tx_byte, txq[0]);
      e_txo = 0; e_rxo = 0; e_txi = 0; e_rxi = 0;
      @(posedge clk); #1;
      if (tx_flush) begin
         txq.delete(); tx_r = 0; tx_w = 0;
      end else begin
         e_txo = wtx && (DEPTH - txs < n);
         e_txi = rtx;
         if (eng_tx_take && txs > 0) begin void'(txq.pop_front()); tx_r = (tx_r + 1) % DEPTH; end
         if (wtx && DEPTH - txs >= n) begin
            for (int k = 0; k < n; k++) txq.push_back(acc_wdata[8*k +: 8]);
            tx_w = (tx_w + n) % DEPTH;
         end
      end
      if (rx_flush) begin
         rxq.delete(); rx_r = 0; rx_w = 0;
      end else begin
         e_rxo = eng_rx_valid && rxs == DEPTH;
         e_rxi = wrx || (rrx && rxs < n);
         if (rrx && rxs >= n) begin
            for (int k = 0; k < n; k++) void'(rxq.pop_front());
            rx_r = (rx_r + n) % DEPTH;
         end
         if (eng_rx_valid && rxs < DEPTH) begin rxq.push_back(eng_rx_byte); rx_w = (rx_w + 1) % DEPTH; end
      end
      chk("R7 tx count", tx_count, txq.size());
      chk("R7 rx count", rx_count, rxq.size());
      chk("R7 tx rptr", tx_rd_ptr, tx_r);
      chk("R7 tx wptr", tx_wr_ptr, tx_w);
      chk("R7 rx rptr", rx_rd_ptr, rx_r);
      chk("R7 rx wptr", rx_wr_ptr, rx_w);
      chk("R4 rx req", rx_req, rxq.size() >= need_of(rx_level_sel));
      chk("R5 tx req", tx_req, DEPTH - txq.size() >= need_of(tx_level_sel));
      chk("R6 rx dma", rx_dma_req, dma_en && (rxq.size() >= need_of(rx_level_sel)));
      chk("R6 tx dma", tx_dma_req, dma_en && (DEPTH - txq.size() >= need_of(tx_level_sel)));
      chk("R9 tx ovr", tx_ovr_evt, e_txo);
      chk("R10 rx ovr", rx_ovr_evt, e_rxo);
      chk("R11 tx ill", tx_ill_evt, e_txi);
      chk("R11 rx ill", rx_ill_evt, e_rxi);
      idle();
   endtask

   task automatic bus_wr(input logic rxs, input logic [1:0] sz, input logic [31:0] d);
      acc_valid = 1; acc_write = 1; acc_rx_side = rxs; acc_size = sz; acc_wdata = d; tick();
   endtask
   task automatic bus_rd(input logic rxs, input logic [1:0] sz);
      acc_valid = 1; acc_write = 0; acc_rx_side = rxs; acc_size = sz; tick();
   endtask
   task automatic eng_in(input logic [7:0] b);
      eng_rx_valid = 1; eng_rx_byte = b; tick();
   endtask
   task automatic eng_take();
      eng_tx_take = 1; tick();
   endtask

   initial begin
      #1000000;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(); dma_en = 0; tx_level_sel = 0; rx_level_sel = 0; rst_n = 0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 tx count", tx_count, 0);   chk("R1 rx count", rx_count, 0);
      chk("R1 tx rptr", tx_rd_ptr, 0);   chk("R1 tx wptr", tx_wr_ptr, 0);
      chk("R1 rx rptr", rx_rd_ptr, 0);   chk("R1 rx wptr", rx_wr_ptr, 0);
      chk("R1 tx req", tx_req, 1);       chk("R1 rx req", rx_req, 0);
      chk("R1 events", {tx_ovr_evt, rx_ovr_evt, tx_ill_evt, rx_ill_evt}, 0);
      rst_n = 1;
      tick();

      // transmit lane order and sizes (R2)
      bus_wr(0, 2, 32'h44332211);
      for (int c = 0; c < 4; c++) begin tx_level_sel = c[1:0]; tick(); end
      eng_take(); eng_take();
      bus_wr(0, 1, 32'h0000BBAA);
      bus_wr(0, 0, 32'h000000CC);
      bus_wr(0, 3, 32'h0000EEDD);
      chk("R2 size3 as word", tx_count, 5);
      // free space 3, word does not fit (R9)
      bus_wr(0, 2, 32'h99887766);
      chk("R9 contents kept", tx_count, 5);
      bus_wr(0, 1, 32'h00005544);
      bus_wr(0, 0, 32'h00000033);
      for (int c = 0; c < 4; c++) begin tx_level_sel = c[1:0]; tick(); end
      bus_wr(0, 0, 32'h000000FF);
      // full: write and take together, legality from start of cycle (R12)
      acc_valid = 1; acc_write = 1; acc_size = 0; acc_wdata = 32'h12; eng_tx_take = 1; tick();
      chk("R12 full push refused", tx_count, 7);
      acc_valid = 1; acc_write = 1; acc_size = 0; acc_wdata = 32'h34; eng_tx_take = 1; tick();
      chk("R12 count held", tx_count, 7);
      bus_rd(0, 0);
      // drain then take on empty (R13)
      for (int i = 0; i < 7; i++) eng_take();
      eng_take();
      chk("R13 empty take count", tx_count, 0);
      chk("R13 empty take rptr", tx_rd_ptr, tx_r);

      // receive fill and overrun (R10), level codes (R4)
      for (int i = 0; i < DEPTH; i++) begin
         rx_level_sel = i[1:0];
         eng_in(8'hA0 + 8'(i));
      end
      for (int c = 0; c < 4; c++) begin rx_level_sel = c[1:0]; tick(); end
      eng_in(8'h5A);
      chk("R10 discarded", rx_count, DEPTH);
      bus_rd(1, 1);
      bus_rd(1, 2);
      bus_rd(1, 2);
      chk("R11 short read kept", rx_count, 2);
      bus_wr(1, 0, 32'h77);
      chk("R11 rx write ignored", rx_count, 2);
      eng_rx_valid = 1; eng_rx_byte = 8'hC3; acc_valid = 1; acc_rx_side = 1; acc_size = 0; tick();
      chk("R12 rx count held", rx_count, 2);
      for (int i = 0; i < 5; i++) eng_in(8'h10 + 8'(i));
      for (int c = 0; c < 4; c++) begin rx_level_sel = c[1:0]; tick(); end

      // DMA routing (R6)
      dma_en = 1; tx_level_sel = 0; rx_level_sel = 1;
      tick();
      bus_wr(0, 2, 32'hDEADBEEF);
      for (int c = 0; c < 4; c++) begin tx_level_sel = c[1:0]; rx_level_sel = c[1:0]; tick(); end
      dma_en = 0; tick();

      // flush isolation and priority (R8)
      tx_flush = 1; acc_valid = 1; acc_write = 1; acc_size = 2; acc_wdata = 32'h01020304; tick();
      chk("R8 tx flushed", tx_count, 0);
      chk("R8 tx wptr zero", tx_wr_ptr, 0);
      chk("R8 rx untouched", rx_count, 7);
      bus_wr(0, 0, 32'h66);
      rx_flush = 1; acc_valid = 1; acc_write = 1; acc_rx_side = 1; tick();
      chk("R8 rx flushed", rx_count, 0);
      chk("R8 rx rptr zero", rx_rd_ptr, 0);
      chk("R8 tx untouched", tx_count, 1);
      bus_rd(1, 0);
      eng_in(8'h42);
      bus_rd(1, 0);
      tick();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule